// File: doc/BRIEF.md
# Load-Use Stall Unit

This block guards a five-stage in-order pipeline against the one case that forwarding cannot cover: an instruction in decode that needs the result of a load that has only just reached execute. The loaded word arrives from memory too late for the dependent instruction to use it in its execute cycle. The unit spots the dependency and holds the front of the pipeline for one cycle. While it holds, it sends an empty slot into execute.

All of its logic is combinational and is evaluated every cycle. A match causes three things. The fetch address register stops updating. The fetch/decode pipeline register stops updating. The execute, memory and writeback control fields that go toward the decode/execute register are forced to zero, so that slot does nothing. In the next cycle the load has moved on to the memory stage and the decode/execute register holds the bubble, so the condition goes away without any state in the unit. The value then reaches the dependent instruction through the forwarding path from the memory/writeback register, which lies outside this block. That path is why the hazard costs exactly one bubble.

The second source field is always compared, even when the decoded instruction does not read it. In that case the unit may stall when no stall is needed, but it never misses a real dependency.

Top module: `loadUseStallUnit`

## Requirements
- R1: When the execute-stage load flag is 1 and the execute-stage destination field equals the decode-stage first source field, the unit signals a stall.
- R2: When the execute-stage load flag is 1 and the execute-stage destination field equals the decode-stage second source field, the unit signals a stall. This comparison is made even for instructions that do not read that field, and it also applies when the register index is 0.
- R3: When the execute-stage load flag is 0, there is never a stall, whatever the register fields hold.
- R4: During a stall, `pcWrite` is 0. With no stall it is 1.
- R5: During a stall, `ifIdWrite` is 0. With no stall it is 1. It always equals `pcWrite`, so fetch and decode hold together.
- R6: During a stall, `exCtrlOut`, `memCtrlOut` and `wbCtrlOut` are all zero, whatever the control inputs hold.
- R7: With no stall, each control output equals its control input bit for bit.
- R8: Suppose a load whose memory control bit 0 (the read flag) is 1 sits in decode, and the next instruction depends on it. When the outputs are fed back through a decode/execute register, exactly one stall cycle occurs. In the following cycle the dependent instruction proceeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ifIdRs | input | REG_W | First source register field of the instruction in decode |
| ifIdRt | input | REG_W | Second source register field of the instruction in decode |
| idExMemRead | input | 1 | Memory-read flag of the instruction in execute (1 = load) |
| idExRt | input | REG_W | Destination field of the load in execute |
| exCtrlIn | input | EX_W | Decoded execute-stage control bits |
| memCtrlIn | input | MEM_W | Decoded memory-stage control bits; bit 0 is the read flag |
| wbCtrlIn | input | WB_W | Decoded writeback-stage control bits |
| pcWrite | output | 1 | Fetch address register update enable |
| ifIdWrite | output | 1 | Fetch/decode register update enable |
| exCtrlOut | output | EX_W | Gated execute control bits toward decode/execute |
| memCtrlOut | output | MEM_W | Gated memory control bits toward decode/execute |
| wbCtrlOut | output | WB_W | Gated writeback control bits toward decode/execute |

## Verification
The bench sweeps every combination of the two source fields, the destination field and the load flag. The sweep separates four cases: a match on the first source, a match on the second source, a match on both, and no match at all. Running it with the load flag both set and clear shows that equal fields alone never cause a stall. During the sweep the control inputs change from one combination to the next, which shows the bubble gating and the pass-through hold for any bit pattern. A short clocked sequence feeds the outputs back through a modelled decode/execute register. It covers three cases: a load followed by a dependent instruction, a load followed by an independent one, and a non-load followed by a dependent one. This shows that a true hazard costs exactly one bubble and that the other two cases cost none.

// File: rtl/luStallPkg.sv
package luStallPkg;

  // Strobes sent from hazard control to the bubble datapath
  typedef struct packed {
    logic pcWrite;
    logic ifIdWrite;
    logic bubble;
  } stallStrobes_t;

endpackage

// File: rtl/luHazardCtl.sv
module luHazardCtl
  import luStallPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] decRs,
  input  logic [REG_W-1:0] decRt,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] exDst,
  output stallStrobes_t    strobes
);
  localparam int NUM_SRC = 2;

  logic [REG_W-1:0] srcField [NUM_SRC];
  logic [NUM_SRC-1:0] srcHit;
  logic needStall;

  assign srcField[0] = decRs;
  assign srcField[1] = decRt;

  // One comparator per source field; the second field is always compared
  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : gSrcCmp
      assign srcHit[s] = (srcField[s] == exDst);
    end
  endgenerate

  assign needStall = exIsLoad & (|srcHit);

  always_comb begin
    strobes.pcWrite   = ~needStall;
    strobes.ifIdWrite = ~needStall;
    strobes.bubble    = needStall;
  end
endmodule

// File: rtl/luBubbleMux.sv
module luBubbleMux
  import luStallPkg::*;
#(
  parameter int CTRL_W = 9
) (
  input  stallStrobes_t      strobes,
  input  logic [CTRL_W-1:0]  ctrlIn,
  output logic [CTRL_W-1:0]  ctrlOut
);
  // Each control bit is gated to zero on a bubble slot
  genvar b;
  generate
    for (b = 0; b < CTRL_W; b++) begin : gGate
      assign ctrlOut[b] = strobes.bubble ? 1'b0 : ctrlIn[b];
    end
  endgenerate
endmodule

// File: rtl/loadUseStallUnit.sv
module loadUseStallUnit
  import luStallPkg::*;
#(
  parameter int REG_W = 5,
  parameter int EX_W  = 4,
  parameter int MEM_W = 3,
  parameter int WB_W  = 2
) (
  input  logic [REG_W-1:0] ifIdRs,
  input  logic [REG_W-1:0] ifIdRt,
  input  logic             idExMemRead,
  input  logic [REG_W-1:0] idExRt,
  input  logic [EX_W-1:0]  exCtrlIn,
  input  logic [MEM_W-1:0] memCtrlIn,
  input  logic [WB_W-1:0]  wbCtrlIn,
  output logic             pcWrite,
  output logic             ifIdWrite,
  output logic [EX_W-1:0]  exCtrlOut,
  output logic [MEM_W-1:0] memCtrlOut,
  output logic [WB_W-1:0]  wbCtrlOut
);
  localparam int CTRL_W = EX_W + MEM_W + WB_W;

  stallStrobes_t strobes;
  logic [CTRL_W-1:0] bundleIn;
  logic [CTRL_W-1:0] bundleOut;

  luHazardCtl #(.REG_W(REG_W)) uCtl (
    .decRs   (ifIdRs),
    .decRt   (ifIdRt),
    .exIsLoad(idExMemRead),
    .exDst   (idExRt),
    .strobes (strobes)
  );

  assign bundleIn = {exCtrlIn, memCtrlIn, wbCtrlIn};

  luBubbleMux #(.CTRL_W(CTRL_W)) uDp (
    .strobes(strobes),
    .ctrlIn (bundleIn),
    .ctrlOut(bundleOut)
  );

  assign {exCtrlOut, memCtrlOut, wbCtrlOut} = bundleOut;
  assign pcWrite   = strobes.pcWrite;
  assign ifIdWrite = strobes.ifIdWrite;
endmodule

// File: rtl/loadUseStallChk.sv
module loadUseStallChk #(
  parameter int REG_W = 5,
  parameter int EX_W  = 4,
  parameter int MEM_W = 3,
  parameter int WB_W  = 2
) (
  input logic [REG_W-1:0] ifIdRs,
  input logic [REG_W-1:0] ifIdRt,
  input logic             idExMemRead,
  input logic [REG_W-1:0] idExRt,
  input logic [EX_W-1:0]  exCtrlIn,
  input logic [MEM_W-1:0] memCtrlIn,
  input logic [WB_W-1:0]  wbCtrlIn,
  input logic             pcWrite,
  input logic             ifIdWrite,
  input logic [EX_W-1:0]  exCtrlOut,
  input logic [MEM_W-1:0] memCtrlOut,
  input logic [WB_W-1:0]  wbCtrlOut
);
  always_comb begin
    AST_STALL_ON_RS: assert (!(idExMemRead && idExRt == ifIdRs) || !pcWrite); // R1
    AST_STALL_ON_RT: assert (!(idExMemRead && idExRt == ifIdRt) || !pcWrite); // R2
    AST_NO_LOAD_NO_STALL: assert (idExMemRead || (pcWrite && ifIdWrite)); // R3
    AST_HOLD_TOGETHER: assert (pcWrite == ifIdWrite); // R5
    AST_BUBBLE_ZERO: assert (pcWrite || (exCtrlOut == '0 && memCtrlOut == '0 && wbCtrlOut == '0)); // R6
    AST_PASS_THROUGH: assert (!pcWrite || (exCtrlOut == exCtrlIn && memCtrlOut == memCtrlIn && wbCtrlOut == wbCtrlIn)); // R7
  end
endmodule

bind loadUseStallUnit loadUseStallChk #(
  .REG_W(REG_W), .EX_W(EX_W), .MEM_W(MEM_W), .WB_W(WB_W)
) chk (
  .ifIdRs(ifIdRs), .ifIdRt(ifIdRt), .idExMemRead(idExMemRead), .idExRt(idExRt),
  .exCtrlIn(exCtrlIn), .memCtrlIn(memCtrlIn), .wbCtrlIn(wbCtrlIn),
  .pcWrite(pcWrite), .ifIdWrite(ifIdWrite),
  .exCtrlOut(exCtrlOut), .memCtrlOut(memCtrlOut), .wbCtrlOut(wbCtrlOut)
);

// File: tb/tb_loadUseStallUnit.sv
module tb_loadUseStallUnit;
  localparam int REG_W = 5;
  localparam int EX_W  = 4;
  localparam int MEM_W = 3;
  localparam int WB_W  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [REG_W-1:0] ifIdRs = '0, ifIdRt = '0, idExRt = '0;
  logic             idExMemRead = 1'b0;
  logic [EX_W-1:0]  exCtrlIn = '0;
  logic [MEM_W-1:0] memCtrlIn = '0;
  logic [WB_W-1:0]  wbCtrlIn = '0;
  logic             pcWrite, ifIdWrite;
  logic [EX_W-1:0]  exCtrlOut;
  logic [MEM_W-1:0] memCtrlOut;
  logic [WB_W-1:0]  wbCtrlOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  loadUseStallUnit #(.REG_W(REG_W), .EX_W(EX_W), .MEM_W(MEM_W), .WB_W(WB_W)) dut (
    .ifIdRs(ifIdRs), .ifIdRt(ifIdRt), .idExMemRead(idExMemRead), .idExRt(idExRt),
    .exCtrlIn(exCtrlIn), .memCtrlIn(memCtrlIn), .wbCtrlIn(wbCtrlIn),
    .pcWrite(pcWrite), .ifIdWrite(ifIdWrite),
    .exCtrlOut(exCtrlOut), .memCtrlOut(memCtrlOut), .wbCtrlOut(wbCtrlOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Clocked pipeline scenario: the decode/execute register is modelled in the bench
  task automatic pipeSeq(input bit firstIsLoad, input bit dependent, input int expStalls, input string req);
    int stalls = 0;
    @(negedge clk);
    // First instruction in decode: destination 2
    idExMemRead = 1'b0; idExRt = 5'd9; ifIdRs = 5'd1; ifIdRt = 5'd2;
    exCtrlIn = 4'h5; memCtrlIn = {2'b00, firstIsLoad}; wbCtrlIn = 2'b11;
    @(posedge clk);
    #1;
    idExMemRead = memCtrlOut[0];
    idExRt      = ifIdRt;
    // Second instruction enters decode (ifIdWrite was 1)
    ifIdRs   = dependent ? 5'd2 : 5'd3;
    ifIdRt   = 5'd4;
    exCtrlIn = 4'hA; memCtrlIn = 3'b000; wbCtrlIn = 2'b10;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (!pcWrite) stalls++;
      @(posedge clk);
      #1;
      idExMemRead = memCtrlOut[0];
      idExRt      = ifIdRt;
    end
    check(stalls == expStalls, req, stalls, expStalls);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rstN = 1'b1;

    // Reset state: no load, all-zero fields -> no stall (R3, R4, R5)
    #1;
    check(pcWrite == 1'b1, "R4 idle pcWrite", pcWrite, 1);
    check(ifIdWrite == 1'b1, "R5 idle ifIdWrite", ifIdWrite, 1);

    // Exhaustive sweep over fields and load flag
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 32; a++) begin
        for (int b = 0; b < 32; b++) begin
          for (int d = 0; d < 32; d++) begin
            bit expStall;
            logic [EX_W-1:0]  eIn;
            logic [MEM_W-1:0] mIn;
            logic [WB_W-1:0]  wIn;
            eIn = 4'((a ^ b) + d);
            mIn = 3'(a + d);
            wIn = 2'(b ^ d);
            idExMemRead = m[0]; ifIdRs = 5'(a); ifIdRt = 5'(b); idExRt = 5'(d);
            exCtrlIn = eIn; memCtrlIn = mIn; wbCtrlIn = wIn;
            #1;
            expStall = (m == 1) && (d == a || d == b);
            if (m == 0)
              check(pcWrite == 1'b1, "R3 no load no stall", pcWrite, 1);
            else if (d == a)
              check(pcWrite == 1'b0, "R1 rs match stalls", pcWrite, 0);
            else if (d == b)
              check(pcWrite == 1'b0, "R2 rt match stalls", pcWrite, 0);
            else
              check(pcWrite == 1'b1, "R4 no match pcWrite", pcWrite, 1);
            check(ifIdWrite == !expStall, "R5 ifIdWrite", ifIdWrite, !expStall);
            if (expStall)
              check({exCtrlOut, memCtrlOut, wbCtrlOut} == '0, "R6 bubble zero",
                    {exCtrlOut, memCtrlOut, wbCtrlOut}, 0);
            else
              check({exCtrlOut, memCtrlOut, wbCtrlOut} == {eIn, mIn, wIn}, "R7 pass-through",
                    {exCtrlOut, memCtrlOut, wbCtrlOut}, {eIn, mIn, wIn});
          end
        end
      end
    end

    // Register 0 destination with rt match still stalls (R2)
    idExMemRead = 1'b1; idExRt = 5'd0; ifIdRs = 5'd7; ifIdRt = 5'd0;
    #1;
    check(pcWrite == 1'b0, "R2 zero index stalls", pcWrite, 0);

    // Clocked sequences
    pipeSeq(1'b1, 1'b1, 1, "R8 load then dependent");
    pipeSeq(1'b1, 1'b0, 0, "R8 load then independent");
    pipeSeq(1'b0, 1'b1, 0, "R3 non-load then dependent");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule